// File: doc/BRIEF.md
# Token-Passing Event Readout Sequencer

This block sequences the digital side of a many-channel radiation front-end. It has 52 channels. Channels 0 to 3 always collect cathode signals. Channels 4 to 51 can each be set up as anode or as pad-sense. A two-bit mode input selects one of three phases:

- **Write-in:** the per-channel enable bits, the pad/anode bits and a pad-mask bit are loaded.
- **Acquisition:** threshold-crossing flags from the discriminators are latched per channel. A global event flag tells the external acquisition system that a qualifying hit is waiting.
- **Readout:** a single token walks across the channels, one step per clock edge. The channel that holds the token drives one-hot select lines for the amplitude and timing multiplexers.

After the last channel, one more slot selects the on-chip temperature sensor. A one-cycle done pulse then ends the scan.

Pad-sense electrodes see induced, bipolar transients. Such a hit is only useful together with an anode or cathode hit, so the pad-mask bit keeps pad-configured channels from raising the event flag on their own.

Top module: `event_readout_seq`

## Requirements
- R1: An asynchronous active-low reset clears all hit latches, every channel enable and every pad bit, sets the pad mask, and drops all outputs to zero with no token held.
- R2: The mode codes are 0 = write-in, 1 = acquisition, 2 = readout; code 3 acts as write-in. Configuration (cfgEn bit k enables channel k, cfgPad bit i makes channel 4+i pad-sense, padMask) is sampled at every clock edge in write-in and ignored in every other mode.
- R3: At each edge in acquisition, every enabled channel whose hit input is high sets its latch. Hits on disabled channels, and hits in write-in or readout, leave the latches unchanged.
- R4: The first edge of an acquisition phase discards all earlier latches, keeping only that cycle's enabled hits.
- R5: With padMask set, latched hits on pad-sense channels do not count toward the event flag. Channels 0 to 3 are never pad-sense. With padMask clear, every latched hit counts.
- R6: eventFlag is the OR of the counted latches in acquisition and readout, and is low in write-in.
- R7: The first edge in readout places the token on channel 0, and each later edge in readout moves it up by one. While the token is on channel k, bit k of ampSel and of timeSel is high.
- R8: The edge after channel 51 moves the token to the temperature slot. In that slot tempSel is high and both channel select buses are zero.
- R9: The edge after the temperature slot drops the token and raises roDone for exactly one cycle. The selects then stay zero until readout is entered again.
- R10: Leaving readout mode drops the token at the next edge without a done pulse.
- R11: At every edge, {ampSel, tempSel} is all-zero or one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout/sequencing clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| modeIn | input | 2 | Operating mode code |
| hitIn | input | 52 | Per-channel discriminator flags |
| cfgEnIn | input | 52 | Per-channel enable, sampled in write-in |
| cfgPadIn | input | 48 | Pad-sense select for channels 4..51, sampled in write-in |
| padMaskIn | input | 1 | Exclude pad hits from the flag, sampled in write-in |
| eventFlag | output | 1 | A qualifying hit is latched |
| ampSel | output | 52 | One-hot amplitude multiplexer select |
| timeSel | output | 52 | One-hot timing multiplexer select |
| tempSel | output | 1 | Temperature-sensor slot select |
| roDone | output | 1 | One-cycle end-of-scan pulse |

## Verification
Two functions can fall in the same edge:
- **Clearing and capturing on acquisition entry.** On the first edge of acquisition, the old latches are cleared and new hits are captured. The bench enters acquisition with and without a hit present. It expects only the new hit to survive.
- **Configuration change against capture.** Configuration inputs can change in the same edge as hit capture. The bench rewrites the enable and pad inputs during acquisition while a hit arrives. It then checks that the flag follows the configuration written earlier.

Random rounds mix configurations, masks and sparse hits. Each flag value is compared with a model of the latches kept in the bench.

// File: rtl/event_readout_seq_pkg.sv
package event_readout_seq_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_ACQ   = 2'd1,
    MODE_READ  = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  // per-edge commands from control to datapath
  typedef struct packed {
    logic loadCfg;      // write-in phase: sample configuration
    logic clearHits;    // first edge of acquisition
    logic captureHits;  // any edge of acquisition
  } strobe_t;

endpackage

// File: rtl/event_readout_seq_ctrl.sv
module event_readout_seq_ctrl
  import event_readout_seq_pkg::*;
#(
  parameter int NUM_CH = 52,
  parameter int POS_W  = $clog2(NUM_CH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeIn,
  output strobe_t          stb,
  output logic             tokActive,
  output logic [POS_W-1:0] tokPos,
  output logic             roDone
);

  localparam logic [POS_W-1:0] TEMP_SLOT = POS_W'(NUM_CH);

  logic isAcq, isRead, isWrite;
  logic prevAcq, prevRead;

  assign isAcq   = (modeIn == MODE_ACQ);
  assign isRead  = (modeIn == MODE_READ);
  assign isWrite = !isAcq && !isRead;

  assign stb.loadCfg     = isWrite;
  assign stb.clearHits   = isAcq && !prevAcq;
  assign stb.captureHits = isAcq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAcq   <= 1'b0;
      prevRead  <= 1'b0;
      tokActive <= 1'b0;
      tokPos    <= '0;
      roDone    <= 1'b0;
    end else begin
      prevAcq  <= isAcq;
      prevRead <= isRead;
      roDone   <= 1'b0;
      if (isRead && !prevRead) begin
        tokActive <= 1'b1;
        tokPos    <= '0;
      end else if (!isRead) begin
        tokActive <= 1'b0;
        tokPos    <= '0;
      end else if (tokActive) begin
        if (tokPos == TEMP_SLOT) begin
          tokActive <= 1'b0;
          tokPos    <= '0;
          roDone    <= 1'b1;
        end else begin
          tokPos <= tokPos + 1'b1;
        end
      end
    end
  end

  // R7: a held token in readout moves exactly one step per edge
  a_r7_token_step: assert property (@(posedge clk) disable iff (!rstN)
    (tokActive && isRead && prevRead && tokPos != TEMP_SLOT)
      |=> (tokActive && tokPos == $past(tokPos) + 1'b1));

  // R9: done is a single-cycle pulse followed by an idle token
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    roDone |=> (!roDone && !tokActive));

  // R10: outside readout no token survives an edge
  a_r10_no_token_outside: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |=> (!tokActive && !roDone));

endmodule

// File: rtl/event_readout_seq_datapath.sv
module event_readout_seq_datapath
  import event_readout_seq_pkg::*;
#(
  parameter int NUM_CATH = 4,
  parameter int NUM_CFG  = 48,
  parameter int NUM_CH   = NUM_CATH + NUM_CFG,
  parameter int POS_W    = $clog2(NUM_CH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [NUM_CH-1:0]  hitIn,
  input  logic [NUM_CH-1:0]  cfgEnIn,
  input  logic [NUM_CFG-1:0] cfgPadIn,
  input  logic               padMaskIn,
  input  logic               tokActive,
  input  logic [POS_W-1:0]   tokPos,
  output logic               eventFlag,
  output logic [NUM_CH-1:0]  ampSel,
  output logic [NUM_CH-1:0]  timeSel,
  output logic               tempSel
);

  localparam logic [POS_W-1:0] TEMP_SLOT = POS_W'(NUM_CH);

  logic [NUM_CH-1:0]  cfgEnQ;
  logic [NUM_CFG-1:0] cfgPadQ;
  logic               padMaskQ;
  logic [NUM_CH-1:0]  hitQ;
  logic [NUM_CH-1:0]  padVec;
  logic [NUM_CH-1:0]  countedHits;
  logic [NUM_CH-1:0]  chanSel;
  logic [NUM_CH-1:0]  newHits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEnQ   <= '0;
      cfgPadQ  <= '0;
      padMaskQ <= 1'b1;
    end else if (stb.loadCfg) begin
      cfgEnQ   <= cfgEnIn;
      cfgPadQ  <= cfgPadIn;
      padMaskQ <= padMaskIn;
    end
  end

  assign newHits = hitIn & cfgEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                hitQ <= '0;
    else if (stb.clearHits)   hitQ <= newHits;
    else if (stb.captureHits) hitQ <= hitQ | newHits;
  end

  assign padVec      = {cfgPadQ, {NUM_CATH{1'b0}}};
  assign countedHits = padMaskQ ? (hitQ & ~padVec) : hitQ;
  assign eventFlag   = !stb.loadCfg && (|countedHits);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_sel
    assign chanSel[k] = tokActive && (tokPos == POS_W'(k));
  end

  assign ampSel  = chanSel;
  assign timeSel = chanSel;
  assign tempSel = tokActive && (tokPos == TEMP_SLOT);

  // R11: at most one readout slot selected
  a_r11_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ampSel, tempSel}));

  // R2: configuration frozen outside write-in
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadCfg |=> ($stable(cfgEnQ) && $stable(cfgPadQ) && $stable(padMaskQ)));

  // R3: latches frozen outside acquisition
  a_r3_hits_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.captureHits |=> $stable(hitQ));

  // R6: no flag in write-in
  a_r6_flag_quiet: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCfg |-> !eventFlag);

endmodule

// File: rtl/event_readout_seq.sv
module event_readout_seq
  import event_readout_seq_pkg::*;
#(
  parameter int NUM_CATH = 4,
  parameter int NUM_CFG  = 48
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [1:0]                    modeIn,
  input  logic [NUM_CATH+NUM_CFG-1:0]   hitIn,
  input  logic [NUM_CATH+NUM_CFG-1:0]   cfgEnIn,
  input  logic [NUM_CFG-1:0]            cfgPadIn,
  input  logic                          padMaskIn,
  output logic                          eventFlag,
  output logic [NUM_CATH+NUM_CFG-1:0]   ampSel,
  output logic [NUM_CATH+NUM_CFG-1:0]   timeSel,
  output logic                          tempSel,
  output logic                          roDone
);

  localparam int NUM_CH = NUM_CATH + NUM_CFG;
  localparam int POS_W  = $clog2(NUM_CH + 1);

  strobe_t          stb;
  logic             tokActive;
  logic [POS_W-1:0] tokPos;

  event_readout_seq_ctrl #(.NUM_CH(NUM_CH), .POS_W(POS_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeIn    (modeIn),
    .stb       (stb),
    .tokActive (tokActive),
    .tokPos    (tokPos),
    .roDone    (roDone)
  );

  event_readout_seq_datapath #(
    .NUM_CATH (NUM_CATH),
    .NUM_CFG  (NUM_CFG),
    .NUM_CH   (NUM_CH),
    .POS_W    (POS_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .hitIn     (hitIn),
    .cfgEnIn   (cfgEnIn),
    .cfgPadIn  (cfgPadIn),
    .padMaskIn (padMaskIn),
    .tokActive (tokActive),
    .tokPos    (tokPos),
    .eventFlag (eventFlag),
    .ampSel    (ampSel),
    .timeSel   (timeSel),
    .tempSel   (tempSel)
  );

endmodule

// File: tb/event_readout_seq_test.sv
module event_readout_seq_test;

  localparam int NCH = 52;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [1:0]      modeIn = 2'd0;
  logic [NCH-1:0]  hitIn = '0;
  logic [NCH-1:0]  cfgEnIn = '0;
  logic [47:0]     cfgPadIn = '0;
  logic            padMaskIn = 1'b0;
  logic            eventFlag, tempSel, roDone;
  logic [NCH-1:0]  ampSel, timeSel;

  int nChecks = 0;
  int nFails  = 0;

  // bench model of configuration and latches
  logic [NCH-1:0] mEn   = '0;
  logic [47:0]    mPad  = '0;
  logic           mMask = 1'b1;
  logic [NCH-1:0] mHits = '0;
  logic [1:0]     mPrev = 2'd0;

  event_readout_seq uut (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .hitIn(hitIn),
    .cfgEnIn(cfgEnIn), .cfgPadIn(cfgPadIn), .padMaskIn(padMaskIn),
    .eventFlag(eventFlag), .ampSel(ampSel), .timeSel(timeSel),
    .tempSel(tempSel), .roDone(roDone)
  );

  always #5 clk = ~clk;

  function automatic logic expFlag();
    logic [NCH-1:0] cnt;
    cnt = mMask ? (mHits & ~{mPad, 4'b0}) : mHits;
    return (modeIn == 2'd1 || modeIn == 2'd2) && (|cnt);
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply model of one edge, then advance past it
  task automatic step();
    if (modeIn == 2'd1) begin
      if (mPrev != 2'd1) mHits = hitIn & mEn;
      else               mHits = mHits | (hitIn & mEn);
    end else if (modeIn != 2'd2) begin
      mEn = cfgEnIn; mPad = cfgPadIn; mMask = padMaskIn;
    end
    mPrev = modeIn;
    @(posedge clk); #1;
  endtask

  initial begin
    #500000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5E));
    #12;
    // R1 reset state
    check("R1 flag", 64'(eventFlag), 64'd0);
    check("R1 sel", 64'(ampSel) | 64'(timeSel), 64'd0);
    check("R1 temp/done", {62'd0, tempSel, roDone}, 64'd0);
    #11 rstN = 1'b1;
    @(posedge clk); #1;

    // write-in: all enabled, channels 4..7 pad, mask on
    cfgEnIn = '1; cfgPadIn = 48'hF; padMaskIn = 1'b1;
    step();
    // acquisition: pad hit alone
    modeIn = 2'd1; hitIn = NCH'(1) << 5;
    step();
    check("R5 pad hit masked", 64'(eventFlag), 64'(expFlag()));
    check("R5 pad hit masked abs", 64'(eventFlag), 64'd0);
    // config changes ignored during acquisition
    cfgEnIn = '0; cfgPadIn = '1; hitIn = NCH'(1) << 10;
    step();
    check("R2 cfg ignored in acq", 64'(eventFlag), 64'd1);
    hitIn = '0;
    step();
    check("R3 latch held", 64'(eventFlag), 64'd1);
    modeIn = 2'd0; #1;
    check("R6 flag low in write-in", 64'(eventFlag), 64'd0);
    cfgEnIn = '1; cfgPadIn = 48'hF; padMaskIn = 1'b0;
    step();
    modeIn = 2'd1; hitIn = '0;
    step();
    check("R4 latches cleared on entry", 64'(eventFlag), 64'd0);
    hitIn = NCH'(1) << 5;
    step();
    check("R5 pad hit counts with mask off", 64'(eventFlag), 64'd1);

    // full readout scan
    hitIn = '0; modeIn = 2'd2;
    step();
    check("R7 token at 0 amp", 64'(ampSel), 64'd1);
    check("R7 token at 0 time", 64'(timeSel), 64'd1);
    check("R6 flag held in readout", 64'(eventFlag), 64'd1);
    for (int k = 1; k < NCH; k++) begin
      step();
      check("R7 token step", 64'(ampSel), 64'(NCH'(1) << k));
    end
    step();
    check("R8 temp slot", {63'd0, tempSel}, 64'd1);
    check("R8 channels idle", 64'(ampSel) | 64'(timeSel), 64'd0);
    step();
    check("R9 done pulse", {63'd0, roDone}, 64'd1);
    check("R9 selects idle", 64'(ampSel) | {63'd0, tempSel}, 64'd0);
    step();
    check("R9 done once", {63'd0, roDone}, 64'd0);
    check("R9 stays idle", 64'(ampSel) | {63'd0, tempSel}, 64'd0);

    // aborted readout
    modeIn = 2'd0; step();
    modeIn = 2'd2; step(); step();
    check("R7 second step", 64'(ampSel), 64'd2);
    modeIn = 2'd1; step();
    check("R10 abort clears", 64'(ampSel) | {62'd0, tempSel, roDone}, 64'd0);

    // disabled channel, mode 3 as write-in
    modeIn = 2'd3; cfgEnIn = ~(NCH'(1) << 20); cfgPadIn = 48'hF; padMaskIn = 1'b1;
    step();
    modeIn = 2'd1; hitIn = NCH'(1) << 20;
    step();
    check("R3 disabled channel ignored", 64'(eventFlag), 64'd0);
    hitIn = NCH'(1) << 2;
    step();
    check("R5 cathode never masked", 64'(eventFlag), 64'd1);

    // random rounds
    for (int r = 0; r < 40; r++) begin
      modeIn = 2'd0; hitIn = '0;
      cfgEnIn  = {$urandom, $urandom} | {$urandom, $urandom};
      cfgPadIn = {$urandom, $urandom};
      padMaskIn = $urandom % 2;
      step();
      modeIn = 2'd1;
      for (int c = 0; c < 3; c++) begin
        hitIn = ($urandom % 3 == 0) ? '0 : (NCH'(1) << ($urandom % NCH));
        step();
        check("R6 random flag", 64'(eventFlag), 64'(expFlag()));
      end
      modeIn = 2'd2; hitIn = NCH'(1) << ($urandom % NCH);
      step();
      check("R7 random token start", 64'(ampSel), 64'd1);
      check("R3 random readout hold", 64'(eventFlag), 64'(expFlag()));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule